// File: doc/BRIEF.md
# Secondary Interrupt Source Aggregator

This block collects peripheral event signals and turns them into seven external interrupt request lines for an 8051-style processor core. Each line has an edge detector with its own polarity and a primary flag. The flag sets on the selected edge. It clears when the core acknowledges that line's vector, except on line 6, which only software can clear. The block drives each line's request as the flag gated by the line enable.

Three lines are shared between several sources: line 2 (two flash-write collision events and an SPI event), line 4 (rise and fall of the PLL lock signal) and line 6 (transfer-busy, one-second tick, watchdog warning). Each of these eight sources has a secondary flag and a secondary enable, held in two byte-wide registers. A line's level is the OR of its enabled secondary flags.

Secondary flags are cleared by writing zeros and ignore written ones. Software can therefore clear one bit with a mask of ones and a single zero. An event that lands between a read and the write-back is not lost. On lines 2 and 6 the tap presented to the core is active-low. A falling-edge setting on those lines therefore fires when the shared level goes high.

Top module: `irq_aggr`

## Requirements
- R1: After reset every primary flag, secondary flag, secondary enable and request output reads 0.
- R2: A secondary flag sets on the clock after its source edge. Bit map: 0 flash collision 0 (rise), 1 flash collision 1 (rise), 2 SPI (rise), 3 PLL lock rise, 4 PLL lock fall, 5 transfer-busy (rise), 6 one-second tick (rise), 7 watchdog warning (rise).
- R3: A write with `reg_sel_i`=0 gives flags = old AND written data. A written 1 leaves its flag unchanged, and a written 0 clears it.
- R4: A hardware set and a software clear of the same secondary flag in one cycle leave the flag at 1.
- R5: A write with `reg_sel_i`=1 loads the secondary enable byte. `reg_rdata_o` shows enables when `reg_sel_i`=1 and flags when it is 0.
- R6: The shared levels are line 2 = OR of enabled bits 0..2, line 4 = OR of enabled bits 3..4 and line 6 = OR of enabled bits 5..7. When a shared level rises, its primary flag sets one clock after the secondary flag. For line 2 this needs `pol_rise_i[0]`=0.
- R7: Polarity of lines 2 and 3. `pol_rise_i[1]`=0 sets line 3 on a falling edge of `ce_busy_i` and 1 sets it on a rising edge. `pol_rise_i[0]`=1 sets line 2 when its shared level falls.
- R8: Line 5 sets on a falling edge of `ee_busy_i`.
- R9: Lines 0 and 1 set on a rising edge of `dio_evt_i[0]` and `dio_evt_i[1]`.
- R10: `ack_i[k]` clears primary flag k for k = 0..5. `ack_i[6]` has no effect, and line 6 clears only through `line6_clr_i`.
- R11: `irq_o` = primary flags AND `line_en_i`.
- R12: A primary set and a clear in the same cycle leave the primary flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dio_evt_i | input | 2 | Digital-I/O events for lines 0 and 1 |
| flash_col_i | input | 2 | Flash-write collision events |
| spi_evt_i | input | 1 | SPI event |
| ce_busy_i | input | 1 | Compute-engine busy (line 3) |
| pll_lock_i | input | 1 | PLL lock status |
| ee_busy_i | input | 1 | EEPROM busy (line 5) |
| xfer_busy_i | input | 1 | Transfer-busy event |
| tick_1s_i | input | 1 | One-second tick |
| wdog_warn_i | input | 1 | Watchdog overflow warning |
| line_en_i | input | 7 | Per-line enable |
| pol_rise_i | input | 2 | Edge select for lines 2 (bit 0) and 3 (bit 1); 0 = falling |
| ack_i | input | 7 | Vector acknowledge per line |
| line6_clr_i | input | 1 | Software clear of line 6 primary flag |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 = flag byte, 1 = enable byte |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected byte |
| line_flag_o | output | 7 | Primary flags |
| irq_o | output | 7 | Enabled requests to the core |

## Verification
The bench builds the block with its default parameters. With those defaults lines 0 to 5 clear on acknowledge and line 6 does not, so both the automatic clear and the software-only clear of line 6 can be exercised. It also covers the one-cycle lag between a secondary flag and its shared line's primary flag. Directed sequences exercise polarity switching, set-beats-clear on both flag levels, and masked writes that race hardware events. A long randomized phase then mixes toggling sources, masked writes, acknowledges and enable changes against a behavioural model.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
  localparam int N_LINES = 7;
  localparam int N_SEC   = 8;
  // secondary bit positions
  localparam int SB_FC0  = 0;
  localparam int SB_FC1  = 1;
  localparam int SB_SPI  = 2;
  localparam int SB_PLLR = 3;
  localparam int SB_PLLF = 4;
  localparam int SB_XFER = 5;
  localparam int SB_TICK = 6;
  localparam int SB_WDOG = 7;
  localparam logic [N_SEC-1:0] GRP_L2 = 8'h07;
  localparam logic [N_SEC-1:0] GRP_L4 = 8'h18;
  localparam logic [N_SEC-1:0] GRP_L6 = 8'hE0;
  // 1 = rising edge sets the secondary flag
  localparam logic [N_SEC-1:0] SEC_RISE = 8'hEF;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  input  logic [W-1:0] rise_sel_i,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sig_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign edge_o[i] = rise_sel_i[i] ? (sig_i[i] & ~prev_q[i]) : (~sig_i[i] & prev_q[i]);
  end
endmodule

// File: rtl/irq_sec_flags.sv
module irq_sec_flags #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         wr_i,
  input  logic         sel_en_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] en_o
);
  logic [N-1:0] keep;

  // written zeros clear, written ones keep
  assign keep = (wr_i && !sel_en_i) ? wdata_i : '1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      flag_o <= '0;
      en_o   <= '0;
    end else begin
      flag_o <= (flag_o & keep) | set_i;
      if (wr_i && sel_en_i) en_o <= wdata_i;
    end

  for (genvar k = 0; k < N; k++) begin : g_chk
    a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> flag_o[k]);
    a_r3_one_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !sel_en_i && wdata_i[k] && flag_o[k]) |=> flag_o[k]);
    a_r3_zero_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !sel_en_i && !wdata_i[k] && !set_i[k]) |=> !flag_o[k]);
  end

  a_r5_en_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_en_i) |=> (en_o == $past(wdata_i)));
endmodule

// File: rtl/irq_pri_flags.sv
module irq_pri_flags #(
  parameter int N = 7,
  parameter logic [N-1:0] AUTO_CLR = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] ack_i,
  input  logic [N-1:0] sw_clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] clr;
  assign clr = (ack_i & AUTO_CLR) | sw_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) flag_o <= '0;
    else         flag_o <= (flag_o & ~clr) | set_i;

  for (genvar k = 0; k < N; k++) begin : g_chk
    a_r12_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> flag_o[k]);
    if (AUTO_CLR[k]) begin : g_auto
      a_r10_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i[k] && !set_i[k]) |=> !flag_o[k]);
    end else begin : g_manual
      a_r10_ack_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o[k] && !sw_clr_i[k]) |=> flag_o[k]);
    end
  end
endmodule

// File: rtl/irq_aggr.sv
module irq_aggr #(
  parameter logic [6:0] LINE_AUTO_CLR = 7'h3F
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] dio_evt_i,
  input  logic [1:0] flash_col_i,
  input  logic       spi_evt_i,
  input  logic       ce_busy_i,
  input  logic       pll_lock_i,
  input  logic       ee_busy_i,
  input  logic       xfer_busy_i,
  input  logic       tick_1s_i,
  input  logic       wdog_warn_i,
  input  logic [6:0] line_en_i,
  input  logic [1:0] pol_rise_i,
  input  logic [6:0] ack_i,
  input  logic       line6_clr_i,
  input  logic       reg_wr_i,
  input  logic       reg_sel_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic [6:0] line_flag_o,
  output logic [6:0] irq_o
);
  import irq_aggr_pkg::*;

  logic [N_SEC-1:0]   sec_src, sec_set, sec_flag, sec_en, sec_act;
  logic [N_LINES-1:0] lvl, lvl_rise, pri_set;
  logic               any2, any4, any6;

  assign sec_src = {wdog_warn_i, tick_1s_i, xfer_busy_i, pll_lock_i, pll_lock_i,
                    spi_evt_i, flash_col_i};

  irq_edge_det #(.W(N_SEC)) u_sec_edge (
    .clk_i, .rst_ni, .sig_i(sec_src), .rise_sel_i(SEC_RISE), .edge_o(sec_set));

  irq_sec_flags #(.N(N_SEC)) u_sec (
    .clk_i, .rst_ni, .set_i(sec_set), .wr_i(reg_wr_i), .sel_en_i(reg_sel_i),
    .wdata_i(reg_wdata_i), .flag_o(sec_flag), .en_o(sec_en));

  assign sec_act = sec_flag & sec_en;
  assign any2 = |(sec_act & GRP_L2);
  assign any4 = |(sec_act & GRP_L4);
  assign any6 = |(sec_act & GRP_L6);

  // lines 2 and 6 drive active-low taps: falling tap == rising shared level
  assign lvl      = {any6, ee_busy_i, any4, ce_busy_i, any2, dio_evt_i};
  assign lvl_rise = {1'b1, 1'b0, 1'b1, pol_rise_i[1], ~pol_rise_i[0], 2'b11};

  irq_edge_det #(.W(N_LINES)) u_line_edge (
    .clk_i, .rst_ni, .sig_i(lvl), .rise_sel_i(lvl_rise), .edge_o(pri_set));

  irq_pri_flags #(.N(N_LINES), .AUTO_CLR(LINE_AUTO_CLR)) u_pri (
    .clk_i, .rst_ni, .set_i(pri_set), .ack_i(ack_i),
    .sw_clr_i({line6_clr_i, 6'b0}), .flag_o(line_flag_o));

  assign irq_o       = line_flag_o & line_en_i;
  assign reg_rdata_o = reg_sel_i ? sec_en : sec_flag;

  a_r6_line4_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(any4) |=> line_flag_o[4]);
endmodule

// File: tb/irq_aggr_bench.sv
module irq_aggr_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic [1:0] dio, fc, pol;
  logic       spi, ce, pll, ee, xfer, tick, wdog, clr6, wr, sel;
  logic [6:0] len, ack;
  logic [7:0] wdata, rdata;
  logic [6:0] lflag, irq;

  irq_aggr u_irq_aggr (
    .clk_i(clk), .rst_ni(rst_n), .dio_evt_i(dio), .flash_col_i(fc), .spi_evt_i(spi),
    .ce_busy_i(ce), .pll_lock_i(pll), .ee_busy_i(ee), .xfer_busy_i(xfer),
    .tick_1s_i(tick), .wdog_warn_i(wdog), .line_en_i(len), .pol_rise_i(pol),
    .ack_i(ack), .line6_clr_i(clr6), .reg_wr_i(wr), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .line_flag_o(lflag), .irq_o(irq));

  int n_chk = 0, n_fail = 0;

  // behavioural reference
  logic [7:0] m_sf, m_se, m_src_p;
  logic [6:0] m_pf, m_lvl_p;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sf = 0; m_se = 0; m_pf = 0; m_src_p = 0; m_lvl_p = 0;
    end else begin
      logic [7:0] src, sset;
      logic [6:0] lvl, pset, pclr;
      src = {wdog, tick, xfer, pll, pll, spi, fc};
      for (int i = 0; i < 8; i++)
        sset[i] = (i == 4) ? (m_src_p[i] && !src[i]) : (src[i] && !m_src_p[i]);
      lvl[0] = dio[0]; lvl[1] = dio[1];
      lvl[2] = (m_sf[0] && m_se[0]) || (m_sf[1] && m_se[1]) || (m_sf[2] && m_se[2]);
      lvl[3] = ce;
      lvl[4] = (m_sf[3] && m_se[3]) || (m_sf[4] && m_se[4]);
      lvl[5] = ee;
      lvl[6] = (m_sf[5] && m_se[5]) || (m_sf[6] && m_se[6]) || (m_sf[7] && m_se[7]);
      pset[0] = lvl[0] && !m_lvl_p[0];
      pset[1] = lvl[1] && !m_lvl_p[1];
      pset[2] = pol[0] ? (!lvl[2] && m_lvl_p[2]) : (lvl[2] && !m_lvl_p[2]);
      pset[3] = pol[1] ? (lvl[3] && !m_lvl_p[3]) : (!lvl[3] && m_lvl_p[3]);
      pset[4] = lvl[4] && !m_lvl_p[4];
      pset[5] = !lvl[5] && m_lvl_p[5];
      pset[6] = lvl[6] && !m_lvl_p[6];
      pclr = {clr6, ack[5:0]};
      for (int k = 0; k < 7; k++)
        if (pset[k]) m_pf[k] = 1'b1; else if (pclr[k]) m_pf[k] = 1'b0;
      for (int i = 0; i < 8; i++)
        if (sset[i]) m_sf[i] = 1'b1;
        else if (wr && !sel && !wdata[i]) m_sf[i] = 1'b0;
      if (wr && sel) m_se = wdata;
      m_src_p = src; m_lvl_p = lvl;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
    chk("R11 irq vs model", {1'b0, irq}, {1'b0, m_pf & len});
    chk("R10 primary flags vs model", {1'b0, lflag}, {1'b0, m_pf});
    chk("R3 read data vs model", rdata, sel ? m_se : m_sf);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; dio = 0; fc = 0; pol = 0; spi = 0; ce = 0; pll = 0; ee = 0;
    xfer = 0; tick = 0; wdog = 0; clr6 = 0; wr = 0; sel = 0; len = 7'h7F;
    ack = 0; wdata = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    step();
    // R1
    chk("R1 flags after reset", rdata, 8'h00);
    chk("R1 irq after reset", {1'b0, irq}, 8'h00);
    sel = 1; #1 chk("R1 enables after reset", rdata, 8'h00);
    // R5
    wr = 1; wdata = 8'hFF; step(); wr = 0;
    chk("R5 enable readback", rdata, 8'hFF);
    // R2, R6
    sel = 0; spi = 1; step();
    chk("R2 spi flag bit2", rdata, 8'h04);
    chk("R6 line2 not yet", {7'b0, lflag[2]}, 8'h00);
    spi = 0; step();
    chk("R6 line2 set one clock later", {7'b0, lflag[2]}, 8'h01);
    // R3
    wr = 1; wdata = 8'hFF; step();
    chk("R3 ones ignored", rdata, 8'h04);
    wdata = 8'hFB; step(); wr = 0;
    chk("R3 zero clears", rdata, 8'h00);
    // R4
    tick = 1; wr = 1; wdata = 8'h00; step(); wr = 0; tick = 0;
    chk("R4 set beats clear", rdata, 8'h40);
    step();
    chk("R6 line6 set", {7'b0, lflag[6]}, 8'h01);
    // R10
    ack = 7'h7F; step(); ack = 0;
    chk("R10 ack clears line2", {7'b0, lflag[2]}, 8'h00);
    chk("R10 ack ignored on line6", {7'b0, lflag[6]}, 8'h01);
    clr6 = 1; step(); clr6 = 0;
    chk("R10 line6 software clear", {7'b0, lflag[6]}, 8'h00);
    // R7
    ce = 1; step();
    chk("R7 line3 no set on rise when falling", {7'b0, lflag[3]}, 8'h00);
    ce = 0; step();
    chk("R7 line3 set on fall", {7'b0, lflag[3]}, 8'h01);
    ack = 7'h08; step(); ack = 0;
    pol = 2'b10; ce = 1; step();
    chk("R7 line3 set on rise when rising", {7'b0, lflag[3]}, 8'h01);
    // R8
    ee = 1; step();
    chk("R8 line5 quiet on rise", {7'b0, lflag[5]}, 8'h00);
    ee = 0; step();
    chk("R8 line5 set on fall", {7'b0, lflag[5]}, 8'h01);
    // R9
    dio = 2'b01; step();
    chk("R9 line0 rise", {7'b0, lflag[0]}, 8'h01);
    dio = 0; ack = 7'h01; step(); ack = 0;
    chk("R10 ack clears line0", {7'b0, lflag[0]}, 8'h00);
    // R12
    dio = 2'b01; ack = 7'h01; step(); ack = 0;
    chk("R12 set beats ack", {7'b0, lflag[0]}, 8'h01);
    // R11
    len = 7'h00; #1 chk("R11 irq gated off", {1'b0, irq}, 8'h00);
    len = 7'h01; #1 chk("R11 irq line0", {1'b0, irq}, 8'h01);
    // randomized phase
    for (int c = 0; c < 6000; c++) begin
      if ($urandom_range(7) == 0) dio[$urandom_range(1)] ^= 1'b1;
      if ($urandom_range(7) == 0) fc[$urandom_range(1)] ^= 1'b1;
      if ($urandom_range(7) == 0) spi = ~spi;
      if ($urandom_range(7) == 0) ce = ~ce;
      if ($urandom_range(7) == 0) pll = ~pll;
      if ($urandom_range(7) == 0) ee = ~ee;
      if ($urandom_range(7) == 0) xfer = ~xfer;
      if ($urandom_range(7) == 0) tick = ~tick;
      if ($urandom_range(7) == 0) wdog = ~wdog;
      if ($urandom_range(31) == 0) pol = 2'($urandom_range(3));
      if ($urandom_range(31) == 0) len = 7'($urandom_range(127));
      ack  = ($urandom_range(3) == 0) ? 7'($urandom_range(127)) : 7'h00;
      clr6 = ($urandom_range(15) == 0);
      sel  = ($urandom_range(3) == 0);
      wr   = ($urandom_range(5) == 0);
      wdata = ($urandom_range(1) == 0) ? ~(8'h01 << $urandom_range(7)) : 8'($urandom_range(255));
      step();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule